// File: doc/BRIEF.md
# Coalescing Cache Access Queue

This block is a request buffer that sits between lane-level load/store traffic and one level of a cache or memory hierarchy. Requests arrive one per cycle with an address, a direction (read or write) and a tag. Each request is stored in a circular queue. Writes are acknowledged as soon as they are stored, so the issuing pipeline never waits on the memory level for a write.

The control logic looks at the head of the queue. It finds the run of adjacent entries that share the head's block address and direction, and issues that whole run as a single downstream block access. Only one access is outstanding at a time. When the memory level answers, the run is retired one entry per cycle. For a read run, every merged request gets its own completion carrying its tag, in queue order. A running counter records how many requests were absorbed into an access that another request had already opened.

The amount of merging depends on three things: the block size, the queue depth and the order in which requests arrive. Entries for the same block that are separated by a different block or a different direction are not combined.

Top module: `blk_coalesce_queue`

## Requirements
- R1: After reset, reqReady is 1, and memReqValid, cplValid and wrAckValid are 0. mergeCount is 0.
- R2: A write accepted at a clock edge (reqValid and reqReady both 1) raises wrAckValid, with wrAckTag equal to its tag, in the following cycle. This holds whatever the state of the downstream side.
- R3: The block address of a request is its address shifted right by log2(BLOCK_BYTES) bits (6 bits by default). memReqBlock carries the block address of the entry at the head of the queue.
- R4: A downstream access covers the longest run of adjacent entries, starting at the head, that share the head's block address and direction. memReqCount is the length of that run, which is at least 1. memReqWrite is 1 for a write run and 0 for a read run.
- R5: A change of block address or of direction ends a run. Entries for the same block that are not adjacent go to separate accesses.
- R6: After the handshake (memReqValid and memReqReady both 1), memReqValid stays 0 until the response has arrived and the run has been retired.
- R7: After memRspValid, a read run produces one cplValid pulse per merged request, one per cycle, with cplTag values in queue order. A write run produces no completion.
- R8: reqReady is 0 while DEPTH entries are held. A request presented while the queue is full is not stored, not acknowledged and never issued.
- R9: At every handshake, mergeCount grows by memReqCount minus one.
- R10: While memReqValid is 1 and memReqReady is 0, memReqValid stays 1 and memReqBlock and memReqWrite hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Queue can accept a request |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Byte address |
| reqTag | input | TAG_W | Requester tag |
| wrAckValid | output | 1 | Write stored acknowledgement |
| wrAckTag | output | TAG_W | Tag of the acknowledged write |
| memReqValid | output | 1 | Coalesced access offered downstream |
| memReqReady | input | 1 | Downstream takes the access |
| memReqWrite | output | 1 | Direction of the access |
| memReqBlock | output | ADDR_W-log2(BLOCK_BYTES) | Block address of the access |
| memReqCount | output | log2(DEPTH+1) | Number of requests merged into the access |
| memRspValid | input | 1 | Downstream finished the outstanding access |
| cplValid | output | 1 | Read completion |
| cplTag | output | TAG_W | Tag of the completed read |
| mergeCount | output | CNT_W | Running count of merged requests |

## Verification
The assertions check on every cycle the properties that depend only on the current and the previous cycle:
- the write acknowledgement follows its acceptance and carries its tag;
- an offered access holds steady under backpressure;
- there is never a second access in flight;
- the merge counter steps by the run length minus one;
- the queue neither overflows nor underflows.

The bench scenarios show the properties that need the whole history of a request stream:
- which entries end up in the same access, including adjacent and non-adjacent same-block patterns and direction changes;
- the exact order of read completion tags;
- that a write offered to a full queue leaves no trace at all.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // strobes sent from the control to the queue storage
  typedef struct packed {
    logic push;
    logic pop;
  } cqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } cqState_e;
endpackage

// File: rtl/cq_store.sv
// Circular entry storage plus the head-run scanner (datapath).
module cq_store
  import cq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 6,
  parameter int BLOCK_BYTES = 64,
  parameter int DEPTH       = 16,
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cqStrobe_t         strobe,
  input  logic              inWrite,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [TAG_W-1:0]  inTag,
  output logic              full,
  output logic              empty,
  output logic [BLK_W-1:0]  headBlock,
  output logic              headWrite,
  output logic [TAG_W-1:0]  headTag,
  output logic [LEN_W-1:0]  runLen
);
  // DEPTH must be a power of two: the pointers wrap naturally.
  logic [BLK_W-1:0] blkMem [DEPTH];
  logic             wrMem  [DEPTH];
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [LEN_W-1:0] fill;

  assign full  = (fill == LEN_W'(DEPTH));
  assign empty = (fill == '0);
  assign headBlock = blkMem[headPtr];
  assign headWrite = wrMem[headPtr];
  assign headTag   = tagMem[headPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      blkMem[tailPtr] <= inAddr[ADDR_W-1:OFF_W];
      wrMem[tailPtr]  <= inWrite;
      tagMem[tailPtr] <= inTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
    end else begin
      if (strobe.push) tailPtr <= tailPtr + 1'b1;
      if (strobe.pop)  headPtr <= headPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // Head-run scan: count adjacent entries matching the head's block and direction.
  logic             scanGoing;
  logic [PTR_W-1:0] scanIdx;
  always_comb begin
    runLen    = '0;
    scanGoing = 1'b1;
    scanIdx   = headPtr;
    for (int i = 0; i < DEPTH; i++) begin
      scanIdx = headPtr + PTR_W'(i);
      if (scanGoing && (LEN_W'(i) < fill) &&
          (blkMem[scanIdx] == blkMem[headPtr]) && (wrMem[scanIdx] == wrMem[headPtr]))
        runLen = runLen + 1'b1;
      else
        scanGoing = 1'b0;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !(strobe.push && !strobe.pop));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);
endmodule

// File: rtl/cq_ctrl.sv
// Issue / wait / retire sequencing, write acknowledge and merge statistics.
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  output logic             wrAckValid,
  output logic [TAG_W-1:0] wrAckTag,
  input  logic             full,
  input  logic             empty,
  input  logic             headWrite,
  input  logic [LEN_W-1:0] runLen,
  output cqStrobe_t        strobe,
  output logic             memReqValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output logic             cplValid,
  output logic [CNT_W-1:0] mergeCount
);
  cqState_e         state;
  logic [LEN_W-1:0] drainLeft;
  logic             groupWr;
  logic             issueFire;

  always_comb begin
    reqReady    = !full;
    strobe.push = reqValid && !full;
    strobe.pop  = (state == ST_DRAIN);
    memReqValid = (state == ST_IDLE) && !empty;
    issueFire   = memReqValid && memReqReady;
    cplValid    = (state == ST_DRAIN) && !groupWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      drainLeft  <= '0;
      groupWr    <= 1'b0;
      mergeCount <= '0;
      wrAckValid <= 1'b0;
      wrAckTag   <= '0;
    end else begin
      wrAckValid <= strobe.push && reqWrite;
      if (strobe.push && reqWrite) wrAckTag <= reqTag;
      case (state)
        ST_IDLE: if (issueFire) begin
          state      <= ST_WAIT;
          drainLeft  <= runLen;
          groupWr    <= headWrite;
          mergeCount <= mergeCount + CNT_W'(runLen) - 1'b1;
        end
        ST_WAIT: if (memRspValid) state <= ST_DRAIN;
        ST_DRAIN: begin
          drainLeft <= drainLeft - 1'b1;
          if (drainLeft == LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_wrack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (wrAckValid && wrAckTag == $past(reqTag)));
  assert_one_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);
  assert_merge_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=>
      (mergeCount == $past(mergeCount) + CNT_W'($past(runLen)) - CNT_W'(1)));
endmodule

// File: rtl/blk_coalesce_queue.sv
module blk_coalesce_queue
  import cq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 6,
  parameter int BLOCK_BYTES = 64,
  parameter int DEPTH       = 16,
  parameter int CNT_W       = 16,
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              wrAckValid,
  output logic [TAG_W-1:0]  wrAckTag,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [BLK_W-1:0]  memReqBlock,
  output logic [LEN_W-1:0]  memReqCount,
  input  logic              memRspValid,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [CNT_W-1:0]  mergeCount
);
  cqStrobe_t        strobe;
  logic             full, empty;
  logic [LEN_W-1:0] runLen;

  cq_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .BLOCK_BYTES(BLOCK_BYTES), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inWrite(reqWrite), .inAddr(reqAddr), .inTag(reqTag),
    .full(full), .empty(empty),
    .headBlock(memReqBlock), .headWrite(memReqWrite), .headTag(cplTag),
    .runLen(runLen)
  );

  cq_ctrl #(.TAG_W(TAG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqTag(reqTag), .reqReady(reqReady),
    .wrAckValid(wrAckValid), .wrAckTag(wrAckTag),
    .full(full), .empty(empty), .headWrite(memReqWrite), .runLen(runLen),
    .strobe(strobe), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .cplValid(cplValid), .mergeCount(mergeCount)
  );

  assign memReqCount = runLen;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqBlock) && $stable(memReqWrite)));
  assert_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqCount != '0));
endmodule

// File: tb/blk_coalesce_queue_tb_top.sv
`timescale 1ns/1ps
module blk_coalesce_queue_tb_top;
  localparam int ADDR_W = 32, TAG_W = 6, DEPTH = 16, CNT_W = 16;
  localparam int BLK_W = 26, LEN_W = 5;
  localparam int NV = 6;

  // stimulus table: 4 requests per vector, bit i of vWr is the direction of request i
  localparam logic [15:0] vAddr [NV][4] = '{
    '{16'h000, 16'h010, 16'h03C, 16'h040},
    '{16'h100, 16'h108, 16'h13F, 16'h120},
    '{16'h200, 16'h204, 16'h208, 16'h20C},
    '{16'h000, 16'h040, 16'h000, 16'h040},
    '{16'h080, 16'h0BF, 16'h0A0, 16'h0A4},
    '{16'h3C0, 16'h3FF, 16'h400, 16'h400}};
  localparam logic [3:0] vWr [NV] = '{4'b0000, 4'b1111, 4'b1010, 4'b0000, 4'b0011, 4'b1000};
  // expected results: accesses issued and merges added
  localparam int vGroups [NV] = '{2, 1, 4, 4, 2, 3};
  localparam int vMerges [NV] = '{2, 3, 0, 0, 2, 1};

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, memReqReady = 0, memRspValid = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqReady, wrAckValid, memReqValid, memReqWrite, cplValid;
  logic [TAG_W-1:0] wrAckTag, cplTag;
  logic [BLK_W-1:0] memReqBlock;
  logic [LEN_W-1:0] memReqCount;
  logic [CNT_W-1:0] mergeCount;

  int checks = 0, failures = 0, cycles = 0;
  int cplN = 0;
  int cplLog [64];

  always #2 clk = ~clk;

  blk_coalesce_queue dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqTag(reqTag), .wrAckValid(wrAckValid), .wrAckTag(wrAckTag),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqBlock(memReqBlock), .memReqCount(memReqCount), .memRspValid(memRspValid),
    .cplValid(cplValid), .cplTag(cplTag), .mergeCount(mergeCount));

  always @(negedge clk) if (rstN && cplValid && cplN < 64) begin
    cplLog[cplN] = int'(cplTag);
    cplN++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives one request for one edge
  task automatic pushReq(input bit wr, input int addr, input int tag);
    chk(reqReady == 1, "R8", "ready before push", int'(reqReady), 1);
    reqValid = 1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqTag = TAG_W'(tag);
    @(negedge clk);
    reqValid = 0;
    if (wr) begin
      chk(wrAckValid == 1, "R2", "write ack", int'(wrAckValid), 1);
      chk(int'(wrAckTag) == tag, "R2", "write ack tag", int'(wrAckTag), tag);
    end
  endtask

  task automatic serveGroup(input int blk, input bit wr, input int cnt);
    for (int k = 0; k < 50 && !memReqValid; k++) @(negedge clk);
    chk(memReqValid == 1, "R4", "access offered", int'(memReqValid), 1);
    chk(int'(memReqBlock) == blk, "R3", "block address", int'(memReqBlock), blk);
    chk(memReqWrite == wr, "R4", "direction", int'(memReqWrite), int'(wr));
    chk(int'(memReqCount) == cnt, "R5", "run length", int'(memReqCount), cnt);
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    chk(memReqValid == 0, "R6", "no second access", int'(memReqValid), 0);
    repeat (2) @(negedge clk);
    chk(memReqValid == 0, "R6", "still waiting", int'(memReqValid), 0);
    memRspValid = 1;
    @(negedge clk);
    memRspValid = 0;
    repeat (cnt + 1) @(negedge clk);
  endtask

  initial begin
    int gBlk [4];
    bit gWr [4];
    int gCnt [4];
    int expTags [16];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1, "R1", "reqReady", int'(reqReady), 1);
    chk(memReqValid == 0, "R1", "memReqValid", int'(memReqValid), 0);
    chk(cplValid == 0, "R1", "cplValid", int'(cplValid), 0);
    chk(wrAckValid == 0, "R1", "wrAckValid", int'(wrAckValid), 0);
    chk(mergeCount == 0, "R1", "mergeCount", int'(mergeCount), 0);
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int nG, nR, m0;
      nG = 0; nR = 0; m0 = int'(mergeCount); cplN = 0;
      // reference grouping computed here from the stimulus
      for (int i = 0; i < 4; i++) begin
        int b;
        b = int'(vAddr[v][i]) >> 6;
        if (i == 0 || b != gBlk[nG-1] || vWr[v][i] != gWr[nG-1]) begin
          gBlk[nG] = b; gWr[nG] = vWr[v][i]; gCnt[nG] = 1; nG++;
        end else gCnt[nG-1]++;
        if (!vWr[v][i]) begin expTags[nR] = v * 4 + i + 1; nR++; end
      end
      chk(nG == vGroups[v], "R5", "table group count", nG, vGroups[v]);
      for (int i = 0; i < 4; i++) pushReq(vWr[v][i], int'(vAddr[v][i]), v * 4 + i + 1);
      for (int g = 0; g < nG; g++) serveGroup(gBlk[g], gWr[g], gCnt[g]);
      chk(memReqValid == 0, "R5", "no extra access", int'(memReqValid), 0);
      chk(int'(mergeCount) - m0 == vMerges[v], "R9", "merge delta", int'(mergeCount) - m0, vMerges[v]);
      chk(cplN == nR, "R7", "completion count", cplN, nR);
      for (int i = 0; i < nR && i < cplN; i++)
        chk(cplLog[i] == expTags[i], "R7", "completion tag order", cplLog[i], expTags[i]);
    end

    // full queue: 16 reads to one block while downstream is stalled
    begin
      int m0;
      m0 = int'(mergeCount); cplN = 0;
      for (int i = 0; i < DEPTH; i++) pushReq(1'b0, 32'h400 + i * 4, 32 + i);
      chk(reqReady == 0, "R8", "ready low when full", int'(reqReady), 0);
      chk(int'(memReqCount) == DEPTH, "R4", "full run length", int'(memReqCount), DEPTH);
      // write while full must be ignored
      reqValid = 1; reqWrite = 1; reqAddr = 32'h400; reqTag = 6'd63;
      @(negedge clk);
      chk(wrAckValid == 0, "R8", "no ack while full", int'(wrAckValid), 0);
      @(negedge clk);
      reqValid = 0;
      chk(wrAckValid == 0, "R8", "no ack while full", int'(wrAckValid), 0);
      serveGroup(32'h10, 1'b0, DEPTH);
      chk(int'(mergeCount) - m0 == DEPTH - 1, "R9", "full merge delta", int'(mergeCount) - m0, DEPTH - 1);
      chk(cplN == DEPTH, "R7", "full completion count", cplN, DEPTH);
      for (int i = 0; i < DEPTH && i < cplN; i++)
        chk(cplLog[i] == 32 + i, "R7", "full completion order", cplLog[i], 32 + i);
      repeat (3) @(negedge clk);
      chk(memReqValid == 0, "R8", "ignored write never issued", int'(memReqValid), 0);
      chk(reqReady == 1, "R8", "ready after drain", int'(reqReady), 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule